// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the host end of a two-wire link to a delta-sigma converter whose single output line has two jobs. While no result is pending it sits high. A falling level means that a conversion has finished. Once that fall is seen, the same line carries the result one bit per serial clock. The reader watches the line through a two-stage synchronizer. It generates the serial clock from a programmed half period, takes each bit when the clock falls, and hands the assembled word to the fabric as a signed value with a one-cycle strobe.

The host sends commands to the converter only through clock counts and clock levels. A poll request adds one clock after the 24 data clocks, which pushes the line back high at once. A calibration request adds two clocks. If the standby level is high when a result becomes ready, the clock is raised and held high for as long as the level stays high. Between reads, the clock stays low until the line has gone high and then fallen again. This keeps clocks out of the converter's update window. A watchdog timer reports a missing ready edge.

Top module: `adc_rdy_reader`

## Requirements
- R1: The serial clock stays low whenever no read is in progress. A read, and the clock's first rising edge, begin only after the synchronized line is seen low. After a read, the next one waits until the line has been high and then low again.
- R2: Each read captures 24 bits, most significant first, sampling the line at the end of every clock-high phase. It presents them on `dataWord` as a two's-complement value, so 0x800000 reads as -8388608 and 0x7FFFFF as 8388607.
- R3: `dataValid` pulses for exactly one cycle per read, when the 24th bit is taken. `dataWord` changes only in that cycle.
- R4: Every clock-high phase and every clock-low phase inside a read lasts exactly max(`sclkHalf`, MIN_HALF) system cycles. A programmed value below MIN_HALF is raised to MIN_HALF.
- R5: A poll request makes the next read issue 25 clock pulses instead of 24.
- R6: A calibration request makes the next read issue 26 clock pulses, and it takes priority over a poll. A request is held until a read starts. A request present in the cycle the read is started applies to that read. A request arriving one cycle later applies to the following read.
- R7: If `standbyReq` is high when the line is seen low, the reader raises the clock, captures nothing, and holds the clock high while `standbyReq` stays high. The high level lasts at least one half period. After release the clock stays low, and the reader waits for the line to go high and fall again.
- R8: While waiting for the line, `timeoutErr` pulses for one cycle every TIMEOUT_CYC cycles without a read start. The clock stays low throughout.
- R9: During and right after reset, `sclk`, `dataValid` and `timeoutErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdoRdy | input | 1 | Converter ready/data line (asynchronous) |
| cmdPoll | input | 1 | One-cycle request: add a 25th clock to the next read |
| cmdCal | input | 1 | One-cycle request: add clocks 25 and 26 to the next read |
| standbyReq | input | 1 | Level: park the clock high at the next ready edge |
| sclkHalf | input | HALF_W | Requested half period of the serial clock in system cycles |
| sclk | output | 1 | Serial clock to the converter |
| dataWord | output | WORD_W | Last captured word, signed |
| dataValid | output | 1 | One-cycle strobe marking a new `dataWord` |
| timeoutErr | output | 1 | One-cycle strobe: no ready edge within TIMEOUT_CYC |

## Verification
A command strobe and the start of a read can land in the same cycle. The question is then which read the request belongs to. The bench knows the synchronizer depth, so it can pulse a calibration or poll request exactly in the cycle the controller commits to a read. It expects 26 or 25 rising clock edges on that very read. It then repeats the pulse one cycle later and expects a plain 24-edge read followed by a 26-edge read. Edge counts come from a behavioural converter model that also returns the word bits, and the captured word is compared with its sign-extended value.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_WAIT_LOW,
    S_WAIT_HIGH,
    S_HIGH,
    S_LOW,
    S_STANDBY,
    S_RESUME
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // take the synchronized line into the shift register
    logic publish;  // last bit: load the output word and raise valid
  } dpStrobe_t;

endpackage

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdoRdy,
  input  dpStrobe_t                strobe,
  output logic                     rdyLow,
  output logic signed [WORD_W-1:0] dataWord,
  output logic                     dataValid
);

  logic syncA, syncB;
  logic [WORD_W-1:0] shiftReg;

  // two-stage synchronizer; idle level of the line is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= sdoRdy;
      syncB <= syncA;
    end
  end

  assign rdyLow = !syncB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      dataWord  <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobe.publish;
      if (strobe.capture) shiftReg <= {shiftReg[WORD_W-2:0], syncB};
      if (strobe.publish) dataWord <= {shiftReg[WORD_W-2:0], syncB};
    end
  end

  // R3: valid never lasts two cycles
  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R3: word only moves together with the strobe
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.publish |=> $stable(dataWord));

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int HALF_W      = 8,
  parameter int MIN_HALF    = 5,
  parameter int TIMEOUT_CYC = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdyLow,
  input  logic              cmdPoll,
  input  logic              cmdCal,
  input  logic              standbyReq,
  input  logic [HALF_W-1:0] sclkHalf,
  output logic              sclk,
  output logic              timeoutErr,
  output dpStrobe_t         strobe
);

  localparam int CLK_W = $clog2(WORD_W + 3);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [HALF_W-1:0] MIN_H   = HALF_W'(MIN_HALF);
  localparam logic [CLK_W-1:0]  N_DATA  = CLK_W'(WORD_W);
  localparam logic [TMR_W-1:0]  TMR_END = TMR_W'(TIMEOUT_CYC - 1);

  rdState_t          state;
  logic              sclkQ;
  logic [HALF_W-1:0] phaseCnt, effHalf;
  logic [CLK_W-1:0]  clkNum, totalClks;
  logic              pendPoll, pendCal, lastPhase, wantCal, wantPoll;
  logic [TMR_W-1:0]  timer;

  assign effHalf   = (sclkHalf < MIN_H) ? MIN_H : sclkHalf;
  assign lastPhase = (phaseCnt >= effHalf - 1'b1);
  assign wantCal   = pendCal | cmdCal;
  assign wantPoll  = pendPoll | cmdPoll;

  assign strobe.capture = (state == S_HIGH) && lastPhase && (clkNum <= N_DATA);
  assign strobe.publish = (state == S_HIGH) && lastPhase && (clkNum == N_DATA);
  assign sclk = sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_WAIT_LOW;
      sclkQ      <= 1'b0;
      phaseCnt   <= '0;
      clkNum     <= '0;
      totalClks  <= N_DATA;
      pendPoll   <= 1'b0;
      pendCal    <= 1'b0;
      timer      <= '0;
      timeoutErr <= 1'b0;
    end else begin
      timeoutErr <= 1'b0;
      pendPoll   <= wantPoll;
      pendCal    <= wantCal;
      case (state)
        S_WAIT_LOW, S_WAIT_HIGH: begin
          if (state == S_WAIT_LOW && rdyLow) begin
            timer    <= '0;
            phaseCnt <= '0;
            sclkQ    <= 1'b1;
            if (standbyReq) begin
              state <= S_STANDBY;
            end else begin
              state     <= S_HIGH;
              clkNum    <= CLK_W'(1);
              totalClks <= wantCal ? N_DATA + CLK_W'(2) :
                           wantPoll ? N_DATA + CLK_W'(1) : N_DATA;
              pendPoll  <= 1'b0;
              pendCal   <= 1'b0;
            end
          end else begin
            if (state == S_WAIT_HIGH && !rdyLow) state <= S_WAIT_LOW;
            if (timer == TMR_END) begin
              timer      <= '0;
              timeoutErr <= 1'b1;
            end else begin
              timer <= timer + 1'b1;
            end
          end
        end
        S_HIGH: begin
          if (lastPhase) begin
            sclkQ    <= 1'b0;
            phaseCnt <= '0;
            state    <= S_LOW;
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        S_LOW: begin
          if (lastPhase) begin
            phaseCnt <= '0;
            if (clkNum == totalClks) begin
              state <= S_WAIT_HIGH;
            end else begin
              clkNum <= clkNum + 1'b1;
              sclkQ  <= 1'b1;
              state  <= S_HIGH;
            end
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        S_STANDBY: begin
          if (!standbyReq && lastPhase) begin
            sclkQ    <= 1'b0;
            phaseCnt <= '0;
            state    <= S_RESUME;
          end else if (!lastPhase) phaseCnt <= phaseCnt + 1'b1;
        end
        S_RESUME: begin
          if (lastPhase) begin
            phaseCnt <= '0;
            state    <= S_WAIT_HIGH;
          end else phaseCnt <= phaseCnt + 1'b1;
        end
        default: state <= S_WAIT_LOW;
      endcase
    end
  end

  // level-length and edge tracking used only by the properties below
  logic              prevSclk;
  logic [HALF_W:0]   widthCnt;
  logic [CLK_W-1:0]  riseCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSclk <= 1'b0;
      widthCnt <= (HALF_W+1)'(MIN_HALF);
      riseCnt  <= '0;
    end else begin
      prevSclk <= sclkQ;
      if (sclkQ != prevSclk) widthCnt <= (HALF_W+1)'(1);
      else if (widthCnt < (HALF_W+1)'(MIN_HALF)) widthCnt <= widthCnt + 1'b1;
      if (state == S_WAIT_LOW) riseCnt <= '0;
      else if (sclkQ && !prevSclk) riseCnt <= riseCnt + 1'b1;
    end
  end

  // R4: no clock level shorter than the minimum half period
  p_min_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ != prevSclk) |-> (widthCnt >= (HALF_W+1)'(MIN_HALF)));

  // R6: never more than data plus two command clocks per read
  p_clock_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sclkQ && !prevSclk) |-> (riseCnt < N_DATA + CLK_W'(2)));

  // R8: a timeout is only reported while the clock is parked low
  p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !sclkQ);

  // R1: the clock stays low in the cycle after a read has fully finished
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_HIGH) |-> !sclkQ);

endmodule

// File: rtl/adc_rdy_reader.sv
module adc_rdy_reader
  import adc_rd_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int HALF_W      = 8,
  parameter int MIN_HALF    = 5,
  parameter int TIMEOUT_CYC = 50_000_000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdoRdy,
  input  logic                     cmdPoll,
  input  logic                     cmdCal,
  input  logic                     standbyReq,
  input  logic [HALF_W-1:0]        sclkHalf,
  output logic                     sclk,
  output logic signed [WORD_W-1:0] dataWord,
  output logic                     dataValid,
  output logic                     timeoutErr
);

  dpStrobe_t strobe;
  logic      rdyLow;

  adc_rd_ctrl #(
    .WORD_W(WORD_W), .HALF_W(HALF_W), .MIN_HALF(MIN_HALF), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rdyLow(rdyLow), .cmdPoll(cmdPoll), .cmdCal(cmdCal),
    .standbyReq(standbyReq), .sclkHalf(sclkHalf), .sclk(sclk),
    .timeoutErr(timeoutErr), .strobe(strobe)
  );

  adc_rd_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .sdoRdy(sdoRdy), .strobe(strobe),
    .rdyLow(rdyLow), .dataWord(dataWord), .dataValid(dataValid)
  );

endmodule

// File: tb/adc_rdy_reader_test.sv
module adc_rdy_reader_test;

  localparam int TMO = 1000;

  logic clk = 1'b0, rstN = 1'b0;
  logic sdoLine = 1'b1, cmdPoll = 1'b0, cmdCal = 1'b0, standbyReq = 1'b0;
  logic [7:0] sclkHalf = 8'd5;
  logic sclk, dataValid, timeoutErr;
  logic signed [23:0] dataWord;

  adc_rdy_reader #(.WORD_W(24), .HALF_W(8), .MIN_HALF(5), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rstN(rstN), .sdoRdy(sdoLine), .cmdPoll(cmdPoll), .cmdCal(cmdCal),
    .standbyReq(standbyReq), .sclkHalf(sclkHalf), .sclk(sclk), .dataWord(dataWord),
    .dataValid(dataValid), .timeoutErr(timeoutErr)
  );

  always #10 clk = ~clk;  // 50 MHz, 20-unit period

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural converter: presents the next bit half a cycle after each rise
  logic [23:0] curWord = '0;
  bit modelActive = 1, windowFlag = 0;
  int riseNum = 0, windowHits = 0;
  always begin
    @(posedge sclk);
    @(negedge clk);
    riseNum++;
    if (windowFlag) windowHits++;
    if (modelActive) begin
      if (riseNum <= 24) sdoLine = curWord[24-riseNum];
      else sdoLine = 1'b1;
    end
  end

  // observation at the inactive edge
  int validCnt = 0, cycleNo = 0, toCnt = 0, lastTo = -1, toGap = -1;
  logic signed [23:0] lastWord = '0;
  bit measuring = 0, seenRise = 0;
  logic prevS = 1'b0;
  int runLen = 0, hiMin, hiMax, loMin, loMax;
  always @(negedge clk) begin
    cycleNo++;
    if (dataValid) begin validCnt++; lastWord = dataWord; end
    if (timeoutErr) begin
      toCnt++;
      if (lastTo >= 0) toGap = cycleNo - lastTo;
      lastTo = cycleNo;
    end
    if (sclk == prevS) runLen++;
    else begin
      if (measuring) begin
        if (!sclk) begin
          if (runLen < hiMin) hiMin = runLen;
          if (runLen > hiMax) hiMax = runLen;
        end else if (seenRise) begin
          if (runLen < loMin) loMin = runLen;
          if (runLen > loMax) loMax = runLen;
        end
        if (sclk) seenRise = 1;
      end
      runLen = 1;
      prevS = sclk;
    end
  end

  // cmdKind: 0 none, 1 poll, 2 cal; cmdTiming: 0 before the fall,
  // 1 in the read-start cycle, 2 one cycle after it
  task automatic doRead(input logic [23:0] w, input int cmdKind, input int cmdTiming,
                        input int expRises, input int half);
    int eff = (half < 5) ? 5 : half;
    int expW = w[23] ? int'(w) - 32'h0100_0000 : int'(w);
    sclkHalf = 8'(half);
    windowFlag = 1; windowHits = 0; modelActive = 1;
    @(negedge clk); sdoLine = 1'b1;
    if (cmdTiming == 0 && cmdKind != 0) begin
      if (cmdKind == 1) cmdPoll = 1'b1; else cmdCal = 1'b1;
      @(negedge clk); cmdPoll = 1'b0; cmdCal = 1'b0;
    end
    repeat (8) @(negedge clk);
    windowFlag = 0; riseNum = 0; validCnt = 0; curWord = w;
    hiMin = 999; hiMax = 0; loMin = 999; loMax = 0; seenRise = 0; measuring = 1;
    sdoLine = 1'b0;
    if (cmdTiming != 0) begin
      repeat (cmdTiming + 1) @(negedge clk);
      if (cmdKind == 1) cmdPoll = 1'b1; else cmdCal = 1'b1;
      @(negedge clk); cmdPoll = 1'b0; cmdCal = 1'b0;
    end
    repeat (expRises * 2 * eff + 20) @(negedge clk);
    measuring = 0;
    check(windowHits == 0, "R1 clock edge while line high", windowHits, 0);
    check(riseNum == expRises, (expRises == 24) ? "R2 data clock count" :
          (expRises == 25) ? "R5 poll clock count" : "R6 cal clock count", riseNum, expRises);
    check(validCnt == 1, "R3 valid pulses per read", validCnt, 1);
    check(int'(lastWord) == expW, "R2 captured word", int'(lastWord), expW);
    check(hiMin == eff && hiMax == eff, "R4 high width", hiMin * 1000 + hiMax, eff * 1001);
    check(loMin == eff && loMax == eff, "R4 low width", loMin * 1000 + loMax, eff * 1001);
    check(sclk == 1'b0, "R1 clock low after read", int'(sclk), 0);
  endtask

  function automatic logic [23:0] wordFor(input int i);
    case (i)
      0: return 24'h000000;
      1: return 24'h7FFFFF;
      2: return 24'h800000;
      3: return 24'hFFFFFF;
      4: return 24'h000001;
      5: return 24'hA5A5A5;
      6: return 24'h5A5A5A;
      7: return 24'hC00003;
      default: return 24'h1 << (i - 8);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(sclk == 0 && dataValid == 0 && timeoutErr == 0, "R9 in reset",
          int'({sclk, dataValid, timeoutErr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclk == 0 && dataValid == 0 && timeoutErr == 0, "R9 after reset",
          int'({sclk, dataValid, timeoutErr}), 0);

    // sweep of words, command modes and half periods
    for (int i = 0; i < 32; i++) begin
      int mode = i % 3;
      int half = (i % 4 == 0) ? 2 : (i % 4 == 1) ? 5 : (i % 4 == 2) ? 6 : 9;
      doRead(wordFor(i), mode, 0, 24 + mode, half);
    end

    // R6 request coinciding with the read-start cycle
    doRead(24'h123456, 2, 1, 26, 5);
    doRead(24'h654321, 1, 1, 25, 6);
    // R6 request one cycle late: this read plain, the next carries it
    doRead(24'hABCDEF, 2, 2, 24, 5);
    doRead(24'h0F0F0F, 0, 0, 26, 5);

    // R7 standby
    standbyReq = 1'b1; modelActive = 0; validCnt = 0; sclkHalf = 8'd5;
    @(negedge clk); sdoLine = 1'b1;
    repeat (8) @(negedge clk);
    sdoLine = 1'b0;
    repeat (10) @(negedge clk);
    check(sclk == 1'b1, "R7 clock parked high", int'(sclk), 1);
    repeat (40) @(negedge clk);
    check(sclk == 1'b1, "R7 clock still high", int'(sclk), 1);
    check(validCnt == 0, "R7 no capture in standby", validCnt, 0);
    standbyReq = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk == 1'b0, "R7 clock low on release", int'(sclk), 0);
    riseNum = 0;
    repeat (30) @(negedge clk);
    check(riseNum == 0, "R7 no clock while line still low", riseNum, 0);
    doRead(24'h3C3C3C, 0, 0, 24, 5);

    // R8 timeout while the line stays high
    sdoLine = 1'b1; toCnt = 0; lastTo = -1; toGap = -1; riseNum = 0;
    repeat (3200) @(negedge clk);
    check(toCnt >= 3 && toCnt <= 4, "R8 timeout pulses", toCnt, 3);
    check(toGap == TMO, "R8 timeout interval", toGap, TMO);
    check(riseNum == 0, "R8 clock quiet while waiting", riseNum, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule